// File: doc/BRIEF.md
# ADC Sample Trace Capture Buffer

This block records a run of converter results into an on-chip word store so that they can be inspected afterwards. Two sample streams arrive at its edge, one from the pressure converter and one from the temperature converter. Each stream is a valid strobe with a data bus. A small control port picks the stream, the stored resolution and whether capture is running. Each accepted sample goes into the next 32-bit word, right-aligned, with the bits above the chosen resolution written as zero.

Capture is single-shot. Turning the enable on from the off state starts a fresh run at word 0. The run ends by itself once the store holds its fixed number of words (2048 by default). Three status outputs report an empty, half-full and full store. A separate flag reports that the store is busy with tracing, so other users of the same RAM, such as a code overlay, can be held off. The host fetches any stored word by its index, and the word appears one cycle after the request.

Top module: `trace_capture`

## Requirements
- R1: After reset `st_empty`=1, `st_half`=0, `st_full`=0, `trace_active`=0 and `rd_data`=0.
- R2: A write on the control port (`ctl_we`=1) loads `ctl_wdata[0]` as the enable. While the enable is 0, no sample from either stream is stored and the status outputs do not change.
- R3: `ctl_wdata[1]` picks the source: 0 stores pressure samples and 1 stores temperature samples. A strobe on the stream that is not selected is ignored.
- R4: `ctl_wdata[2]` picks the resolution. With 0, the stored word is the low 16 data bits and bits 31:16 are zero. With 1, it is the low 24 data bits and bits 31:24 are zero.
- R5: Accepted samples are written to consecutive word indices, starting at index 0 and keeping the order in which they arrived.
- R6: `st_empty` is 1 exactly when no word is stored. `st_half` is 1 when at least 1024 words are stored. `st_full` is 1 when 2048 words are stored.
- R7: Once the store is full, further samples are ignored. No stored word is overwritten, and `st_full` stays 1 until the next restart.
- R8: A control write with enable=1 while the enable is 0 restarts the run: the word count returns to zero and `st_empty` becomes 1 on the next cycle.
- R9: A read request (`rd_en`=1, `rd_idx`=i) puts word i on `rd_data` one clock later. Without a request, `rd_data` holds its value.
- R10: `trace_active` equals the enable, which marks the store as unavailable to any other user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Control value: bit0 enable, bit1 source, bit2 resolution |
| press_valid | input | 1 | Pressure sample strobe |
| press_data | input | 24 | Pressure sample value |
| temp_valid | input | 1 | Temperature sample strobe |
| temp_data | input | 24 | Temperature sample value |
| rd_en | input | 1 | Read request |
| rd_idx | input | 11 | Word index to read |
| rd_data | output | 32 | Word read, one cycle after the request |
| st_empty | output | 1 | No word stored |
| st_half | output | 1 | At least half the store is filled |
| st_full | output | 1 | Store is full, capture halted |
| trace_active | output | 1 | Tracing enabled, store reserved |

## Verification
The hardest state to reach from the ports is the boundary at the end of a run. The sample that would be word 2049 must be dropped without wrapping onto word 0, and the half-full flag must change exactly between the 1023rd and the 1024th word. The bench drives a full run of 2048 pressure samples, each with its own counter-derived value, checks the flags on both sides of each threshold, and then offers extra samples. Finally it reads back the whole store, including word 0, against the queue of expected words.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;

   typedef enum logic {
      SRC_PRESS = 1'b0,
      SRC_TEMP  = 1'b1
   } trace_src_e;

   typedef enum logic {
      RES_NARROW = 1'b0,
      RES_WIDE   = 1'b1
   } trace_res_e;

   typedef struct packed {
      logic       enable;
      trace_src_e src;
      trace_res_e res;
   } trace_cfg_t;

   localparam int CTL_W       = 3;
   localparam int CTL_BIT_EN  = 0;
   localparam int CTL_BIT_SRC = 1;
   localparam int CTL_BIT_RES = 2;

endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
   import trace_cap_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output trace_cfg_t       cfg,
   output logic             restart
);

   // A new run begins only when the enable goes from off to on.
   assign restart = ctl_we && ctl_wdata[CTL_BIT_EN] && !cfg.enable;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg.enable <= 1'b0;
         cfg.src    <= SRC_PRESS;
         cfg.res    <= RES_NARROW;
      end else if (ctl_we) begin
         cfg.enable <= ctl_wdata[CTL_BIT_EN];
         cfg.src    <= trace_src_e'(ctl_wdata[CTL_BIT_SRC]);
         cfg.res    <= trace_res_e'(ctl_wdata[CTL_BIT_RES]);
      end
   end

endmodule

// File: rtl/trace_fmt.sv
module trace_fmt
   import trace_cap_pkg::*;
#(
   parameter int ADC_W    = 24,
   parameter int NARROW_W = 16,
   parameter int WORD_W   = 32
) (
   input  trace_cfg_t        cfg,
   input  logic              press_valid,
   input  logic [ADC_W-1:0]  press_data,
   input  logic              temp_valid,
   input  logic [ADC_W-1:0]  temp_data,
   output logic              s_valid,
   output logic [WORD_W-1:0] s_word
);

   logic [ADC_W-1:0] pick;
   logic [ADC_W-1:0] masked;

   always_comb begin
      if (cfg.src == SRC_TEMP) begin
         s_valid = temp_valid;
         pick    = temp_data;
      end else begin
         s_valid = press_valid;
         pick    = press_data;
      end
      masked = pick;
      if (cfg.res == RES_NARROW)
         masked[ADC_W-1:NARROW_W] = '0;
   end

   generate
      if (WORD_W > ADC_W) begin : g_pad
         assign s_word = {{(WORD_W-ADC_W){1'b0}}, masked};
      end else begin : g_exact
         assign s_word = masked;
      end
   endgenerate

endmodule

// File: rtl/trace_wr.sv
module trace_wr #(
   parameter int DEPTH = 2048,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          enable,
   input  logic          s_valid,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic          empty,
   output logic          half,
   output logic          full
);

   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
   localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);

   logic [CW-1:0] cnt;

   assign full  = (cnt == CNT_FULL);
   assign half  = (cnt >= CNT_HALF);
   assign empty = (cnt == '0);
   assign we    = enable && s_valid && !full;
   assign waddr = cnt[AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (we)      cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/trace_ram.sv
module trace_ram #(
   parameter int DEPTH  = 2048,
   parameter int WORD_W = 32,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              rd_en,
   input  logic [AW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= mem[raddr];
   end

endmodule

// File: rtl/trace_capture.sv
module trace_capture
   import trace_cap_pkg::*;
#(
   parameter int DEPTH    = 2048,
   parameter int ADC_W    = 24,
   parameter int NARROW_W = 16,
   parameter int WORD_W   = 32,
   localparam int AW      = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [CTL_W-1:0]  ctl_wdata,
   input  logic              press_valid,
   input  logic [ADC_W-1:0]  press_data,
   input  logic              temp_valid,
   input  logic [ADC_W-1:0]  temp_data,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_idx,
   output logic [WORD_W-1:0] rd_data,
   output logic              st_empty,
   output logic              st_half,
   output logic              st_full,
   output logic              trace_active
);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("trace_capture: DEPTH must be a power of two of at least 4");
      end
      if (NARROW_W < 1 || NARROW_W >= ADC_W) begin : g_bad_narrow
         $error("trace_capture: NARROW_W must lie between 1 and ADC_W-1");
      end
      if (ADC_W > WORD_W) begin : g_bad_word
         $error("trace_capture: ADC_W must not exceed WORD_W");
      end
   endgenerate

   trace_cfg_t        cfg;
   logic              restart;
   logic              s_valid;
   logic [WORD_W-1:0] s_word;
   logic              we;
   logic [AW-1:0]     waddr;

   trace_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (ctl_we),
      .ctl_wdata(ctl_wdata),
      .cfg      (cfg),
      .restart  (restart)
   );

   trace_fmt #(.ADC_W(ADC_W), .NARROW_W(NARROW_W), .WORD_W(WORD_W)) u_fmt (
      .cfg        (cfg),
      .press_valid(press_valid),
      .press_data (press_data),
      .temp_valid (temp_valid),
      .temp_data  (temp_data),
      .s_valid    (s_valid),
      .s_word     (s_word)
   );

   trace_wr #(.DEPTH(DEPTH)) u_wr (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(restart),
      .enable (cfg.enable),
      .s_valid(s_valid),
      .we     (we),
      .waddr  (waddr),
      .empty  (st_empty),
      .half   (st_half),
      .full   (st_full)
   );

   trace_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ram (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (we),
      .waddr(waddr),
      .wdata(s_word),
      .rd_en(rd_en),
      .raddr(rd_idx),
      .rdata(rd_data)
   );

   assign trace_active = cfg.enable;

endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk (
   input logic clk,
   input logic rst_n,
   input logic ctl_we,
   input logic ctl_en_bit,
   input logic st_empty,
   input logic st_half,
   input logic st_full,
   input logic trace_active
);

   logic go;
   assign go = ctl_we && ctl_en_bit && !trace_active;

   a_r6_full_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
      st_full |-> st_half);

   a_r6_empty_not_half: assert property (@(posedge clk) disable iff (!rst_n)
      st_empty |-> !st_half);

   a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st_full && !go) |=> st_full);

   a_r8_restart_empty: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> st_empty);

   a_r10_active_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (trace_active == $past(ctl_en_bit)));

   a_r2_idle_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!trace_active && !ctl_we) |=> $stable({st_empty, st_half, st_full}));

endmodule

bind trace_capture trace_capture_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_we      (ctl_we),
   .ctl_en_bit  (ctl_wdata[0]),
   .st_empty    (st_empty),
   .st_half     (st_half),
   .st_full     (st_full),
   .trace_active(trace_active)
);

// File: tb/trace_capture_bench.sv
`timescale 1ns/1ps
module trace_capture_bench;

   localparam int DEPTH = 2048;
   localparam int AW    = 11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [2:0]  ctl_wdata = '0;
   logic        press_valid = 1'b0;
   logic [23:0] press_data = '0;
   logic        temp_valid = 1'b0;
   logic [23:0] temp_data = '0;
   logic        rd_en = 1'b0;
   logic [AW-1:0] rd_idx = '0;
   logic [31:0] rd_data;
   logic        st_empty, st_half, st_full, trace_active;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench-side model
   bit m_en = 0, m_src = 0, m_res = 0;
   int m_cnt = 0;
   logic [31:0] exp_q[$];
   int rd_base = 0;

   always #5 clk = ~clk;

   trace_capture u_trace_capture (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .press_valid(press_valid), .press_data(press_data),
      .temp_valid(temp_valid), .temp_data(temp_data),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
      .st_empty(st_empty), .st_half(st_half), .st_full(st_full),
      .trace_active(trace_active)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic check_status(input string req, input bit e, input bit h, input bit f);
      check(req, {29'd0, st_empty, st_half, st_full}, {29'd0, e, h, f});
   endtask

   task automatic ctl_write(input bit en, input bit src, input bit res);
      @(negedge clk);
      ctl_we = 1'b1;
      ctl_wdata = {res, src, en};
      @(negedge clk);
      ctl_we = 1'b0;
      if (en && !m_en) begin
         m_cnt = 0;
         exp_q.delete();
         rd_base = 0;
      end
      m_en = en; m_src = src; m_res = res;
   endtask

   // driver: presents one cycle of stream activity and records what should be stored
   task automatic drive(input bit pv, input logic [23:0] pd, input bit tv, input logic [23:0] td);
      bit v;
      logic [23:0] d;
      @(negedge clk);
      press_valid = pv; press_data = pd;
      temp_valid = tv;  temp_data = td;
      v = m_src ? tv : pv;
      d = m_src ? td : pd;
      if (m_en && v && m_cnt < DEPTH) begin
         exp_q.push_back(m_res ? {8'd0, d} : {16'd0, d[15:0]});
         m_cnt++;
      end
      @(negedge clk);
      press_valid = 1'b0;
      temp_valid = 1'b0;
   endtask

   // monitor side: read words in order and compare against the queue
   task automatic drain(input string req, input int n);
      for (int i = 0; i < n; i++) begin
         logic [31:0] e;
         e = exp_q.pop_front();
         @(negedge clk);
         rd_en = 1'b1;
         rd_idx = AW'(rd_base);
         @(negedge clk);
         rd_en = 1'b0;
         check(req, rd_data, e);
         rd_base++;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_status("R1 status", 1, 0, 0);
      check("R1 trace_active", {31'd0, trace_active}, 32'd0);
      check("R1 rd_data", rd_data, 32'd0);

      // R2 samples while disabled are ignored
      drive(1, 24'h123456, 1, 24'h654321);
      drive(1, 24'h000001, 0, 24'h0);
      check_status("R2 disabled no capture", 1, 0, 0);

      // R10, R8 start pressure, 16-bit
      ctl_write(1, 0, 0);
      check("R10 active on", {31'd0, trace_active}, 32'd1);
      check_status("R8 fresh run empty", 1, 0, 0);
      drive(1, 24'hABCDEF, 1, 24'h111111);   // R3 pressure taken, R4 upper cleared
      drive(0, 24'h0, 1, 24'h222222);        // R3 temperature ignored
      drive(1, 24'h123456, 0, 24'h0);
      drive(1, 24'h00FFFF, 0, 24'h0);
      check_status("R6 non-empty", 0, 0, 0);
      drain("R4 R5 narrow pressure", 3);
      held = rd_data;
      repeat (2) @(negedge clk);
      check("R9 rd_data held", rd_data, held);

      // R2 disable, then R8 restart on temperature, 24-bit
      ctl_write(0, 0, 0);
      check("R10 active off", {31'd0, trace_active}, 32'd0);
      drive(1, 24'h777777, 0, 24'h0);
      check_status("R2 disabled status held", 0, 0, 0);
      ctl_write(1, 1, 1);
      check_status("R8 restart empties", 1, 0, 0);
      drive(1, 24'h999999, 1, 24'hABCDEF);
      drive(1, 24'h555555, 0, 24'h0);
      drive(0, 24'h0, 1, 24'h800001);
      drain("R3 R4 wide temperature", 2);

      // R6 R7 full run, pressure 24-bit
      ctl_write(0, 0, 1);
      ctl_write(1, 0, 1);
      for (int i = 0; i < 1023; i++)
         drive(1, {8'(i * 7), 16'(i * 3 + 1)}, 0, 24'h0);
      check_status("R6 1023 below half", 0, 0, 0);
      drive(1, 24'hC0FFEE, 0, 24'h0);
      check_status("R6 1024 half", 0, 1, 0);
      for (int i = 1024; i < 2047; i++)
         drive(1, {8'(i * 7), 16'(i * 3 + 1)}, 0, 24'h0);
      check_status("R6 2047 not full", 0, 1, 0);
      drive(1, 24'hFACADE, 0, 24'h0);
      check_status("R6 2048 full", 0, 1, 1);
      drive(1, 24'h0BAD01, 0, 24'h0);
      drive(1, 24'h0BAD02, 0, 24'h0);
      check_status("R7 full holds", 0, 1, 1);
      check("R7 model count", 32'(exp_q.size()), 32'(DEPTH));
      drain("R5 R7 full readback", DEPTH);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule